// File: doc/BRIEF.md
# Clock Event Interrupt Register

This block is a single 32-bit control and status word for the clock subsystem. Eight event inputs each set a sticky flag. The events are the stabilisation of five oscillator or PLL sources, two clock-monitor faults and one high-speed crystal stuck condition. Software reads the flags and enables over a simple register bus. It writes per-flag enables, and it clears flags by writing ones. Flags, enables and clears each sit in their own byte lane of the word, so byte and half-word writes touch only the lanes whose strobes are set.

Two outputs leave the block. The first is a maskable interrupt: it is active when any of the first seven flags is set while its enable is also set. The second is the stuck-clock indication, which follows the eighth flag with no enable in its path. Both outputs are registered.

Top module: `clkevt_irq_regs`

## Requirements
- R1: After synchronous reset every flag and enable is 0, `evt_irq` and `stuck_irq` are 0, and the register reads 0x00000000.
- R2: A 1 on `evt_in[i]` in a cycle sets flag i, which reads back at bit i (bits 7:0). Bits 0..4 are the five stabilisation events, bit 5 and bit 6 are the two monitor faults, and bit 7 is crystal stuck.
- R3: A write with `reg_be[2]` set and a 1 in bit 16+i clears flag i. A 0 in that bit leaves the flag unchanged.
- R4: If the clear for flag i and the event for flag i occur in the same cycle, the flag ends set.
- R5: Bits 14:8 are read-write enables for flags 6..0 (bit 8+i enables flag i). They load only on a write with `reg_be[1]` set.
- R6: A byte lane whose strobe is 0 is unaffected by a write, whatever its data.
- R7: Writes to bits 7:0 never change a flag.
- R8: Bit 15 and bits 31:16 always read 0.
- R9: `evt_irq` equals the OR over i in 0..6 of (flag i AND enable i), one cycle after that state.
- R10: `stuck_irq` equals flag 7, one cycle after that state, independent of any enable.
- R11: A read returns data in the cycle after `reg_rd`. With no read, or with an address whose word index differs from the register's, `reg_rdata` is 0. Writes to other word addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Byte address; bits 5:2 select the word |
| reg_wr | input | 1 | Write request |
| reg_be | input | 4 | Byte-lane write strobes |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read request |
| reg_rdata | output | 32 | Registered read data |
| evt_in | input | 8 | Event pulses, one per flag |
| evt_irq | output | 1 | Maskable interrupt |
| stuck_irq | output | 1 | Unmaskable crystal-stuck indication |

## Verification
Flag and enable state changes at the clock edge that samples the event or write. A read issued after that edge returns the new value one edge later. Both interrupt outputs follow the state by one further edge. The bench drives every stimulus on a falling edge and holds it for exactly one rising edge. It reads back at the falling edge after the capture edge, and it waits one extra falling edge before it samples `evt_irq` or `stuck_irq`. As a result, each check looks at the first cycle in which the result is due.

// File: rtl/clkevt_pkg.sv
package clkevt_pkg;
  localparam int LANE_W    = 8;
  localparam int FLAG_N    = 8;
  localparam int MASKED_N  = 7;
  localparam int LANE_FLAG = 0;
  localparam int LANE_EN   = 1;
  localparam int LANE_CLR  = 2;

  typedef struct packed {
    logic                en_we;
    logic [MASKED_N-1:0] en_wdata;
    logic [FLAG_N-1:0]   clr;
  } wr_cmd_t;
endpackage

// File: rtl/clkevt_wr_decode.sv
module clkevt_wr_decode
  import clkevt_pkg::*;
#(
  parameter int              ADDR_W     = 6,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 6'h08,
  parameter int              DATA_W     = 32,
  localparam int             BE_W       = DATA_W / LANE_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [BE_W-1:0]   be,
  input  logic [DATA_W-1:0] wdata,
  output logic              sel,
  output wr_cmd_t           cmd
);
  logic wr_hit;
  logic decode_unused;

  assign sel    = (addr[ADDR_W-1:2] == REG_OFFSET[ADDR_W-1:2]);
  assign wr_hit = wr && sel;

  always_comb begin
    cmd          = '0;
    cmd.en_we    = wr_hit && be[LANE_EN];
    cmd.en_wdata = wdata[LANE_EN*LANE_W +: MASKED_N];
    if (wr_hit && be[LANE_CLR])
      cmd.clr = wdata[LANE_CLR*LANE_W +: FLAG_N];
  end

  // flag lane and reserved lanes carry no meaning on a write
  assign decode_unused = ^{addr[1:0], be[LANE_FLAG], be[BE_W-1],
                           wdata[LANE_FLAG*LANE_W +: LANE_W],
                           wdata[LANE_EN*LANE_W + MASKED_N],
                           wdata[DATA_W-1:(LANE_CLR+1)*LANE_W]};
endmodule

// File: rtl/clkevt_flag_bank.sv
module clkevt_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end

    assert_evt_wins_R4: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> flags[i]);
    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !set[i]) |=> !flags[i]);
    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (rst)
      (!set[i] && !flags[i]) |=> !flags[i]);
  end
endmodule

// File: rtl/clkevt_en_reg.sv
module clkevt_en_reg #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst)     en_q <= '0;
    else if (we) en_q <= wdata;
  end

  assert_en_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(en_q));
  assert_en_load_R5: assert property (@(posedge clk) disable iff (rst)
    we |=> (en_q == $past(wdata)));
endmodule

// File: rtl/clkevt_irq_out.sv
module clkevt_irq_out #(
  parameter int N_MASKED = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_MASKED:0]   flags,
  input  logic [N_MASKED-1:0] en,
  output logic                irq,
  output logic                stuck
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq   <= 1'b0;
      stuck <= 1'b0;
    end else begin
      irq   <= |(flags[N_MASKED-1:0] & en);
      stuck <= flags[N_MASKED];
    end
  end

  assert_irq_on_R9: assert property (@(posedge clk) disable iff (rst)
    (|(flags[N_MASKED-1:0] & en)) |=> irq);
  assert_irq_off_R9: assert property (@(posedge clk) disable iff (rst)
    !(|(flags[N_MASKED-1:0] & en)) |=> !irq);
  assert_stuck_on_R10: assert property (@(posedge clk) disable iff (rst)
    flags[N_MASKED] |=> stuck);
  assert_stuck_off_R10: assert property (@(posedge clk) disable iff (rst)
    !flags[N_MASKED] |=> !stuck);
endmodule

// File: rtl/clkevt_irq_regs.sv
module clkevt_irq_regs
  import clkevt_pkg::*;
#(
  parameter int                ADDR_W     = 6,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 6'h08,
  parameter int                DATA_W     = 32,
  localparam int               BE_W       = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [BE_W-1:0]   reg_be,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [FLAG_N-1:0] evt_in,
  output logic              evt_irq,
  output logic              stuck_irq
);
  wr_cmd_t             cmd;
  logic                sel;
  logic [FLAG_N-1:0]   flags;
  logic [MASKED_N-1:0] en_q;
  logic [DATA_W-1:0]   word;

  clkevt_wr_decode #(
    .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET), .DATA_W(DATA_W)
  ) u_dec (
    .addr(reg_addr), .wr(reg_wr), .be(reg_be), .wdata(reg_wdata),
    .sel(sel), .cmd(cmd)
  );

  clkevt_flag_bank #(.N(FLAG_N)) u_flags (
    .clk(clk), .rst(rst), .set(evt_in), .clr(cmd.clr), .flags(flags)
  );

  clkevt_en_reg #(.N(MASKED_N)) u_en (
    .clk(clk), .rst(rst), .we(cmd.en_we), .wdata(cmd.en_wdata), .en_q(en_q)
  );

  clkevt_irq_out #(.N_MASKED(MASKED_N)) u_out (
    .clk(clk), .rst(rst), .flags(flags), .en(en_q),
    .irq(evt_irq), .stuck(stuck_irq)
  );

  always_comb begin
    word = '0;
    word[LANE_FLAG*LANE_W +: FLAG_N] = flags;
    word[LANE_EN*LANE_W +: MASKED_N] = en_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                reg_rdata <= '0;
    else if (reg_rd && sel) reg_rdata <= word;
    else                    reg_rdata <= '0;
  end

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DATA_W-1:LANE_EN*LANE_W + MASKED_N] == '0);
  assert_idle_read_R11: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> (reg_rdata == '0));
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!evt_irq && !stuck_irq && reg_rdata == '0));
endmodule

// File: tb/clkevt_irq_regs_bench.sv
module clkevt_irq_regs_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  reg_addr;
  logic        reg_wr;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata;
  logic        reg_rd;
  logic [31:0] reg_rdata;
  logic [7:0]  evt_in;
  logic        evt_irq;
  logic        stuck_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clkevt_irq_regs u_clkevt_irq_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .evt_in(evt_in), .evt_irq(evt_irq),
    .stuck_irq(stuck_irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [5:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b1; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '0; reg_wdata = '0;
  endtask

  task automatic bus_read(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse(logic [7:0] m);
    @(negedge clk);
    evt_in = m;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic expect_word(string req, logic [31:0] exp);
    logic [31:0] d;
    bus_read(6'h08, d);
    check(req, d, exp);
  endtask

  task automatic expect_outs(string req, logic irq_exp, logic stuck_exp);
    @(negedge clk);
    check({req, " evt_irq"}, {31'b0, evt_irq}, {31'b0, irq_exp});
    check({req, " stuck_irq"}, {31'b0, stuck_irq}, {31'b0, stuck_exp});
  endtask

  task automatic t_reset;
    expect_word("R1 reset word", 32'h0);
    expect_outs("R1 reset outputs", 1'b0, 1'b0);
  endtask

  task automatic t_events;
    pulse(8'h15);
    expect_word("R2 flags set", 32'h0000_0015);
    expect_outs("R9 disabled flags", 1'b0, 1'b0);
  endtask

  task automatic t_flag_lane;
    bus_write(6'h08, 4'b0001, 32'h0000_00FF);
    expect_word("R7 byte write to flags", 32'h0000_0015);
    bus_write(6'h08, 4'b1111, 32'h0000_00EA);
    expect_word("R7 word write to flags", 32'h0000_0015);
  endtask

  task automatic t_enables;
    bus_write(6'h08, 4'b0010, 32'h0000_FF00);
    expect_word("R5 R8 enables, bit15 zero", 32'h0000_7F15);
    expect_outs("R9 enabled", 1'b1, 1'b0);
  endtask

  task automatic t_strobes;
    bus_write(6'h08, 4'b0001, 32'h00FF_0000);
    expect_word("R6 clear lane unstrobed", 32'h0000_7F15);
    bus_write(6'h08, 4'b0100, 32'h0001_0000);
    expect_word("R3 R6 clear bit0, enables kept", 32'h0000_7F14);
    bus_write(6'h08, 4'b0100, 32'h0000_0000);
    expect_word("R3 zero clear no effect", 32'h0000_7F14);
  endtask

  task automatic t_masking;
    bus_write(6'h08, 4'b0010, 32'h0000_0A00);
    expect_word("R5 partial enables", 32'h0000_0A14);
    expect_outs("R9 masked", 1'b0, 1'b0);
    pulse(8'h08);
    expect_outs("R9 enabled flag3", 1'b1, 1'b0);
    expect_word("R2 flag3", 32'h0000_0A1C);
  endtask

  task automatic t_collide;
    @(negedge clk);
    reg_addr = 6'h08; reg_wr = 1'b1; reg_be = 4'b0100;
    reg_wdata = 32'h000A_0000; evt_in = 8'h02;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '0; reg_wdata = '0; evt_in = '0;
    expect_word("R4 event beats clear", 32'h0000_0A16);
  endtask

  task automatic t_stuck;
    pulse(8'h80);
    expect_outs("R10 stuck set", 1'b1, 1'b1);
    expect_word("R2 stuck flag", 32'h0000_0A96);
    bus_write(6'h08, 4'b0100, 32'h0080_0000);
    expect_outs("R10 stuck cleared", 1'b1, 1'b0);
  endtask

  task automatic t_address;
    logic [31:0] d;
    bus_write(6'h0C, 4'b1111, 32'hFFFF_FFFF);
    expect_word("R11 foreign write ignored", 32'h0000_0A16);
    bus_read(6'h0C, d);
    check("R11 foreign read zero", d, 32'h0);
    bus_read(6'h0A, d);
    check("R11 byte address in word", d, 32'h0000_0A16);
    @(negedge clk);
    check("R11 idle read zero", reg_rdata, 32'h0);
  endtask

  task automatic t_word;
    bus_write(6'h08, 4'b1111, 32'hFFFF_FFFF);
    expect_word("R8 R3 word write readback", 32'h0000_7F00);
    expect_outs("R9 R10 all clear", 1'b0, 1'b0);
  endtask

  initial begin
    rst = 1'b1; reg_addr = '0; reg_wr = 1'b0; reg_be = '0;
    reg_wdata = '0; reg_rd = 1'b0; evt_in = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_events();
    t_flag_lane();
    t_enables();
    t_strobes();
    t_masking();
    t_collide();
    t_stuck();
    t_address();
    t_word();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule